// File: doc/BRIEF.md
# GF(31) Linear System Solver

This block finds the unique vector x that satisfies A·x = b, where A is a square N×N matrix and every entry, right-hand side and unknown is an element of the prime field GF(31). It serves the signing path of a multivariate signature scheme, where the oil variables come out of such a system once the vinegar variables are fixed. The default size is N = 20.

The caller streams the augmented matrix in one row per accepted cycle, first row first. Each row carries the N coefficients of that equation followed by its right-hand side. When the last row is taken, the block starts solving by itself. For each column it picks as pivot the first row, at or below the diagonal, whose entry in that column is nonzero. It swaps that row into place and clears the column in every lower row, one row per cycle. Back substitution then runs from the last unknown up to the first. A column with no nonzero candidate stops the solve at once and raises a singular flag. The field inverses come from a small table of 31 entries.

The result flags and the solution stay on the outputs until the first row of the next system is accepted.

Top module: `gf31_linsolve`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `sol_valid` and `sing_err` are 0 and the block waits for row 0.
- R2: A row is taken on each clock edge where `load_valid` is 1 and `busy` is 0. Rows arrive in equation order 0 to N-1. Coefficient j of a row sits at `load_row[5j+4:5j]` for j < N, and the right-hand side sits at `load_row[5N+4:5N]`. All values are in 0..30. Idle cycles between rows are allowed.
- R3: On the edge that takes row N-1, `busy` rises. While `busy` is 1, `load_valid` is ignored, and the solution it produces is unchanged.
- R4: For a nonsingular system, `busy` falls, `sol_valid` becomes 1 with `sing_err` 0, and `x_out[5i+4:5i]` holds unknown x_i such that A·x = b mod 31.
- R5: A zero on the diagonal, or any zero entry where a pivot is expected, is resolved by taking the first nonzero entry at or below the diagonal and swapping rows. The result is then the same unique solution.
- R6: If some column has no nonzero pivot candidate, the solve stops with `sing_err` 1 and `sol_valid` 0.
- R7: `sol_valid` and `sing_err` are never 1 together. Both are 0 while `busy` is 1. Both hold their value until row 0 of the next system is accepted, which clears them on that edge.
- R8: A nonsingular solve keeps `busy` at 1 for exactly N(N+1)/2 + N cycles. That is one pivot cycle per column, one cycle per row eliminated below each pivot, and one cycle per unknown in back substitution.
- R9: A singular solve that fails at column c keeps `busy` at 1 for exactly (N + (N-1) + ... + (N-c+1)) + 1 cycles, counted from the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_valid | input | 1 | A row is offered on `load_row` |
| load_row | input | 5(N+1) | Row coefficients, then the right-hand side, 5 bits each |
| busy | output | 1 | The solve is in progress |
| sol_valid | output | 1 | `x_out` holds the solution |
| sing_err | output | 1 | The matrix was found singular |
| x_out | output | 5N | The solution vector, unknown i at bits 5i+4:5i |

## Verification
Two events can fall in the same cycle. One is a row offered on `load_valid`; the other is either a solve still in progress or the result flags that a new row must clear. The bench drives junk rows during the first cycles of a solve and checks that the flags, the timing and the recovered vector are exactly those of the original system. It also starts the next system the cycle after `busy` falls, so the clearing edge is compared against the reference model on that very cycle. Singular systems that fail at column 0 and at a late column show that the abort cycle count and the flag agree with the model's own elimination.

// File: rtl/gf31_pkg.sv
// gf31_pkg: shared field arithmetic and state type for the GF(31) solver.
// Assumes every operand is already reduced into 0..30.
package gf31_pkg;

    localparam int GF_W = 5;
    localparam int GF_Q = 31;

    typedef logic [GF_W-1:0] gf_t;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_PIV  = 2'd1,
        ST_ELIM = 2'd2,
        ST_BACK = 2'd3
    } solve_st_e;

    // Sum of two field elements.
    function automatic gf_t gf_add(input gf_t a, input gf_t b);
        logic [GF_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return (s >= 6'(GF_Q)) ? GF_W'(s - 6'(GF_Q)) : GF_W'(s);
    endfunction

    // Difference a - b in the field.
    function automatic gf_t gf_sub(input gf_t a, input gf_t b);
        logic [GF_W:0] s;
        s = (a >= b) ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + 6'(GF_Q) - {1'b0, b});
        return GF_W'(s);
    endfunction

    // Product folded with 32 = 1 mod 31, then one conditional subtract.
    function automatic gf_t gf_mul(input gf_t a, input gf_t b);
        logic [2*GF_W-1:0] p;
        logic [GF_W:0]     s;
        p = {5'd0, a} * {5'd0, b};
        s = {1'b0, p[2*GF_W-1:GF_W]} + {1'b0, p[GF_W-1:0]};
        return (s >= 6'(GF_Q)) ? GF_W'(s - 6'(GF_Q)) : GF_W'(s);
    endfunction

    // Multiplicative inverse by search; used only to build constant tables.
    function automatic gf_t gf_inv_calc(input int a);
        gf_t r;
        r = '0;
        for (int t = 1; t < GF_Q; t++) begin
            if (((a * t) % GF_Q) == 1) r = GF_W'(t);
        end
        return r;
    endfunction

endpackage

// File: rtl/gf31_inv_lut.sv
// gf31_inv_lut: combinational inverse table. Input 0 (no inverse) maps to 0.
// Assumes input in 0..30; entry 31 is unused and holds 0.
module gf31_inv_lut
    import gf31_pkg::*;
(
    input  gf_t val_in,
    output gf_t inv_out
);
    localparam int ENTRIES = 1 << GF_W;

    gf_t tbl [ENTRIES];

    // Each entry is a constant computed at elaboration.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_tbl
        assign tbl[g] = (g < GF_Q) ? gf_inv_calc(g) : '0;
    end

    assign inv_out = tbl[val_in];
endmodule

// File: rtl/gf31_pivot_find.sv
// gf31_pivot_find: returns the lowest row index r >= col_idx whose entry
// in the current column is nonzero. Assumes col_idx < ROWS.
module gf31_pivot_find
    import gf31_pkg::*;
#(
    parameter int ROWS = 20,
    parameter int IW   = 5
) (
    input  logic [ROWS-1:0][GF_W-1:0] col_vals,
    input  logic [IW-1:0]             col_idx,
    output logic                      found,
    output logic [IW-1:0]             piv_idx
);
    // Scan downward from the top row index so the smallest qualifying row wins.
    always_comb begin
        found   = 1'b0;
        piv_idx = col_idx;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (r >= int'(col_idx) && col_vals[r] != '0) begin
                found   = 1'b1;
                piv_idx = IW'(r);
            end
        end
    end
endmodule

// File: rtl/gf31_row_elim.sv
// gf31_row_elim: clears column col_idx of the target row using the pivot row.
// Every column right of col_idx gets tgt[j] - (tgt[k]*inv)*piv[j]; the pivot
// column becomes 0; columns left of it pass through. Assumes piv_inv is the
// inverse of piv_row[col_idx].
module gf31_row_elim
    import gf31_pkg::*;
#(
    parameter int COLS = 21,
    parameter int IW   = 5
) (
    input  logic [COLS-1:0][GF_W-1:0] piv_row,
    input  logic [COLS-1:0][GF_W-1:0] tgt_row,
    input  gf_t                       piv_inv,
    input  logic [IW-1:0]             col_idx,
    output logic [COLS-1:0][GF_W-1:0] new_row
);
    gf_t factor;

    // Row multiplier: the target's pivot-column entry divided by the pivot.
    always_comb factor = gf_mul(tgt_row[col_idx], piv_inv);

    // All columns are updated in parallel.
    for (genvar j = 0; j < COLS; j++) begin : g_col
        always_comb begin
            if (j > int'(col_idx))
                new_row[j] = gf_sub(tgt_row[j], gf_mul(factor, piv_row[j]));
            else if (j == int'(col_idx))
                new_row[j] = '0;
            else
                new_row[j] = tgt_row[j];
        end
    end
endmodule

// File: rtl/gf31_back_sub.sv
// gf31_back_sub: one step of back substitution for row row_idx of an upper
// triangular system: x_i = (b_i - sum_{j>i} a_ij*x_j) * inv(a_ii).
// Assumes the unknowns above row_idx are already final in x_vals.
module gf31_back_sub
    import gf31_pkg::*;
#(
    parameter int N  = 20,
    parameter int IW = 5
) (
    input  logic [N:0][GF_W-1:0]   row_vals,
    input  logic [N-1:0][GF_W-1:0] x_vals,
    input  logic [IW-1:0]          row_idx,
    input  gf_t                    diag_inv,
    output gf_t                    x_new
);
    localparam int AW = 2 * GF_W + $clog2(N + 1);

    logic [AW-1:0] acc;
    gf_t           acc_red;

    // Wide sum of the known terms, reduced once at the end.
    always_comb begin
        acc = '0;
        for (int j = 0; j < N; j++) begin
            if (j > int'(row_idx))
                acc = acc + AW'(row_vals[j]) * AW'(x_vals[j]);
        end
        acc_red = GF_W'(acc % AW'(GF_Q));
    end

    // Solve for the diagonal unknown.
    always_comb x_new = gf_mul(gf_sub(row_vals[N], acc_red), diag_inv);
endmodule

// File: rtl/gf31_linsolve.sv
// gf31_linsolve: loads an N x (N+1) augmented matrix over GF(31) one row per
// accepted cycle, runs forward elimination with first-nonzero pivoting and
// row swap (one cycle per pivot, one per eliminated row), then back
// substitution (one cycle per unknown). Reports the solution or a singular
// flag. Assumes all loaded values are in 0..30 and N >= 2.
module gf31_linsolve
    import gf31_pkg::*;
#(
    parameter int N = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_valid,
    input  logic [(N+1)*5-1:0]    load_row,
    output logic                  busy,
    output logic                  sol_valid,
    output logic                  sing_err,
    output logic [N*5-1:0]        x_out
);
    localparam int C  = N + 1;
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    typedef logic [C-1:0][GF_W-1:0] row_t;

    solve_st_e             state;
    row_t                  mat [N];
    logic [IW-1:0]         row_cnt;
    logic [IW-1:0]         k_q;
    logic [IW-1:0]         i_q;
    gf_t                   piv_inv_q;
    logic [N-1:0][GF_W-1:0] x_q;
    logic                  sv_q;
    logic                  err_q;

    logic [N-1:0][GF_W-1:0] col_k;
    logic                  piv_found;
    logic [IW-1:0]         piv_idx;
    gf_t                   lut_in;
    gf_t                   lut_out;
    row_t                  elim_row;
    gf_t                   x_step;
    row_t                  in_row;

    assign in_row = load_row;

    // Column k of every stored row, fed to the pivot search.
    for (genvar r = 0; r < N; r++) begin : g_colk
        assign col_k[r] = mat[r][k_q];
    end

    gf31_pivot_find #(.ROWS(N), .IW(IW)) u_pivot (
        .col_vals (col_k),
        .col_idx  (k_q),
        .found    (piv_found),
        .piv_idx  (piv_idx)
    );

    // One inverse table shared: pivot entry in the pivot cycle, diagonal in back substitution.
    always_comb lut_in = (state == ST_BACK) ? mat[i_q][i_q] : col_k[piv_idx];

    gf31_inv_lut u_inv (
        .val_in  (lut_in),
        .inv_out (lut_out)
    );

    gf31_row_elim #(.COLS(C), .IW(IW)) u_elim (
        .piv_row (mat[k_q]),
        .tgt_row (mat[i_q]),
        .piv_inv (piv_inv_q),
        .col_idx (k_q),
        .new_row (elim_row)
    );

    gf31_back_sub #(.N(N), .IW(IW)) u_back (
        .row_vals (mat[i_q]),
        .x_vals   (x_q),
        .row_idx  (i_q),
        .diag_inv (lut_out),
        .x_new    (x_step)
    );

    // Control sequence: load, pivot, eliminate, back-substitute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_LOAD;
            row_cnt   <= '0;
            k_q       <= '0;
            i_q       <= '0;
            piv_inv_q <= '0;
            sv_q      <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            case (state)
                ST_LOAD: begin
                    if (load_valid) begin
                        sv_q  <= 1'b0;
                        err_q <= 1'b0;
                        if (row_cnt == LAST) begin
                            row_cnt <= '0;
                            k_q     <= '0;
                            state   <= ST_PIV;
                        end else begin
                            row_cnt <= row_cnt + 1'b1;
                        end
                    end
                end
                ST_PIV: begin
                    if (!piv_found) begin
                        err_q <= 1'b1;
                        state <= ST_LOAD;
                    end else begin
                        piv_inv_q <= lut_out;
                        if (k_q == LAST) begin
                            i_q   <= LAST;
                            state <= ST_BACK;
                        end else begin
                            i_q   <= k_q + 1'b1;
                            state <= ST_ELIM;
                        end
                    end
                end
                ST_ELIM: begin
                    if (i_q == LAST) begin
                        k_q   <= k_q + 1'b1;
                        state <= ST_PIV;
                    end else begin
                        i_q <= i_q + 1'b1;
                    end
                end
                ST_BACK: begin
                    if (i_q == '0) begin
                        sv_q  <= 1'b1;
                        state <= ST_LOAD;
                    end else begin
                        i_q <= i_q - 1'b1;
                    end
                end
                default: state <= ST_LOAD;
            endcase
        end
    end

    // Matrix storage: row load, pivot swap, and row elimination write-back.
    always_ff @(posedge clk) begin
        if (state == ST_LOAD && load_valid) begin
            mat[row_cnt] <= in_row;
        end else if (state == ST_PIV && piv_found) begin
            mat[k_q]     <= mat[piv_idx];
            mat[piv_idx] <= mat[k_q];
        end else if (state == ST_ELIM) begin
            mat[i_q] <= elim_row;
        end
    end

    // Solution register: cleared when back substitution starts, filled bottom-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
        end else if (state == ST_PIV && piv_found && k_q == LAST) begin
            x_q <= '0;
        end else if (state == ST_BACK) begin
            x_q[i_q] <= x_step;
        end
    end

    assign busy      = (state != ST_LOAD);
    assign sol_valid = sv_q;
    assign sing_err  = err_q;
    assign x_out     = x_q;

    // R7: the two result flags exclude each other.
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sol_valid && sing_err));

    // R7: no result is shown while a solve runs.
    a_r7_flags_low_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!sol_valid && !sing_err));

    // R3: taking the last row starts the solve on the next cycle.
    a_r3_start_after_last_row: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load_valid && row_cnt == LAST) |=> busy);

    // R5: after the swap, the pivot row used for elimination has a nonzero pivot.
    a_r5_pivot_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ELIM) |-> (mat[k_q][k_q] != '0 && piv_inv_q != '0));

    // R6: an empty pivot column ends the solve with the singular flag.
    a_r6_abort_on_empty_column: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PIV && !piv_found) |=> (sing_err && !busy));

    // R4: back substitution only meets a triangular matrix with nonzero diagonal.
    a_r4_back_diag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BACK) |-> (mat[i_q][i_q] != '0));

endmodule

// File: tb/gf31_linsolve_bench.sv
// gf31_linsolve_bench: behavioural reference model of the solver's cycle
// timing and results, compared on every clock.
module gf31_linsolve_bench;
    localparam int N = 20;
    localparam int Q = 31;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                load_valid = 1'b0;
    logic [(N+1)*5-1:0]  load_row = '0;
    logic                busy;
    logic                sol_valid;
    logic                sing_err;
    logic [N*5-1:0]      x_out;

    gf31_linsolve #(.N(N)) u_gf31_linsolve (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (load_valid),
        .load_row   (load_row),
        .busy       (busy),
        .sol_valid  (sol_valid),
        .sing_err   (sing_err),
        .x_out      (x_out)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit ended = 0;

    int    gA [N][N+1];
    int    gx [N];
    int    pend_lat, pend_x [N];
    bit    pend_sing;
    string pend_tag;

    // Reference model state.
    bit    exp_busy = 0, exp_sv = 0, exp_err = 0;
    int    exp_rows = 0, exp_cnt = 0;
    int    act_x [N];
    bit    act_sing;
    string act_tag = "R8";

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic int inv31(input int a);
        for (int t = 1; t < Q; t++) if ((a * t) % Q == 1) return t;
        return 0;
    endfunction

    // First column with no pivot candidate, or N when nonsingular.
    function automatic int ref_fail_col();
        int m [N][N+1];
        for (int r = 0; r < N; r++) for (int c = 0; c <= N; c++) m[r][c] = gA[r][c];
        for (int k = 0; k < N; k++) begin
            int p = -1;
            for (int r = N - 1; r >= k; r--) if (m[r][k] != 0) p = r;
            if (p < 0) return k;
            for (int c = 0; c <= N; c++) begin
                int t = m[k][c]; m[k][c] = m[p][c]; m[p][c] = t;
            end
            for (int r = k + 1; r < N; r++) begin
                int f = (m[r][k] * inv31(m[k][k])) % Q;
                for (int c = 0; c <= N; c++) m[r][c] = ((m[r][c] - f * m[k][c]) % Q + Q) % Q;
            end
        end
        return N;
    endfunction

    function automatic int lat_of(input int fc);
        int s = 0;
        if (fc == N) return N * (N + 1) / 2 + N;
        for (int k = 0; k < fc; k++) s += N - k;
        return s + 1;
    endfunction

    function automatic void build_rhs();
        for (int r = 0; r < N; r++) begin
            int s = 0;
            for (int j = 0; j < N; j++) s += gA[r][j] * gx[j];
            gA[r][N] = s % Q;
        end
    endfunction

    // Model: advances on each clock edge from the inputs driven at the previous falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_busy = 0; exp_sv = 0; exp_err = 0; exp_rows = 0; exp_cnt = 0;
        end else if (exp_busy) begin
            exp_cnt--;
            if (exp_cnt == 0) begin
                exp_busy = 0;
                exp_sv   = !act_sing;
                exp_err  = act_sing;
            end
        end else if (load_valid) begin
            exp_sv = 0; exp_err = 0;
            exp_rows++;
            if (exp_rows == N) begin
                exp_rows = 0;
                exp_busy = 1;
                exp_cnt  = pend_lat;
                act_sing = pend_sing;
                act_tag  = pend_tag;
                for (int i = 0; i < N; i++) act_x[i] = pend_x[i];
            end
        end
    end

    // Compare outputs mid-cycle once reset is released.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !ended) begin
            chk({"R3 ", act_tag, " busy"}, busy, exp_busy);
            chk({"R7 sol_valid ", act_tag}, sol_valid, exp_sv);
            chk({"R6 R7 sing_err ", act_tag}, sing_err, exp_err);
            if (exp_sv) begin
                int mism = 0;
                for (int i = 0; i < N; i++)
                    if (int'(x_out[5*i +: 5]) != act_x[i]) mism++;
                chk("R2 R4 R5 solution mismatching unknowns", mism, 0);
            end
        end
        if (cyc > 150000 && !ended) begin
            ended = 1;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Drive one system; junk rows may follow while the solve runs.
    task automatic run_system(input string tag, input int gap_row, input bit junk);
        int fc = ref_fail_col();
        pend_lat  = lat_of(fc);
        pend_sing = (fc != N);
        pend_tag  = tag;
        for (int i = 0; i < N; i++) pend_x[i] = gx[i];
        for (int r = 0; r < N; r++) begin
            if (r == gap_row) begin
                @(negedge clk); load_valid = 1'b0;
            end
            @(negedge clk);
            load_valid = 1'b1;
            for (int c = 0; c <= N; c++) load_row[5*c +: 5] = 5'(gA[r][c]);
        end
        @(negedge clk);
        load_valid = 1'b0;
        if (junk) begin
            for (int t = 0; t < 3; t++) begin
                load_valid = 1'b1;
                for (int c = 0; c <= N; c++) load_row[5*c +: 5] = 5'($urandom % Q);
                @(negedge clk);
            end
            load_valid = 1'b0;
        end
        while (exp_busy) @(negedge clk);
    endtask

    function automatic void rand_x();
        for (int i = 0; i < N; i++) gx[i] = $urandom % Q;
    endfunction

    // Random nonsingular matrix; optionally with a zero diagonal.
    function automatic void rand_nonsingular(input bit zero_diag);
        do begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++)
                    gA[r][c] = (zero_diag && r == c) ? 0 : int'($urandom % Q);
            build_rhs();
        end while (ref_fail_col() != N);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk("R1 busy after reset", busy, 0);
        chk("R1 sol_valid after reset", sol_valid, 0);
        chk("R1 sing_err after reset", sing_err, 0);
        rst_n = 1'b1;

        // R4 R8: identity matrix.
        rand_x();
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) gA[r][c] = (r == c) ? 1 : 0;
        build_rhs();
        run_system("R8", -1, 0);

        // R2 R4 R8: dense random systems, one with an idle gap between rows.
        for (int t = 0; t < 3; t++) begin
            rand_x(); rand_nonsingular(0);
            run_system("R8", (t == 1) ? 7 : -1, 0);
        end

        // R5: every diagonal entry starts at zero.
        rand_x(); rand_nonsingular(1);
        run_system("R8", -1, 0);

        // R3: rows offered while busy are ignored.
        rand_x(); rand_nonsingular(0);
        run_system("R8", -1, 1);

        // R6 R9: last row duplicates row 0.
        rand_x(); rand_nonsingular(0);
        for (int c = 0; c <= N; c++) gA[N-1][c] = gA[0][c];
        run_system("R9", -1, 0);

        // R6 R9: first column all zero, so the abort comes at column 0.
        rand_x(); rand_nonsingular(0);
        for (int r = 0; r < N; r++) gA[r][0] = 0;
        build_rhs();
        run_system("R9", -1, 0);

        // R7: the next system follows at once and clears the singular flag.
        rand_x(); rand_nonsingular(0);
        run_system("R8", -1, 0);

        repeat (3) @(negedge clk);
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule